// File: doc/BRIEF.md
# DRAM Physical Address Translator

This block takes a physical byte address and splits it into the coordinates a DRAM command sequencer needs: channel, rank, bank, row and column. Two channels are supported. In interleaved mode successive cache lines alternate between them. In fill mode channel 0 holds every address below a programmed capacity and channel 1 holds the rest. Within a channel, per-rank upper-limit registers find the rank. Per-rank geometry registers give the bank, row and column widths.

Four bit-order schemes are programmable. Two are the baseline orders. The page-kept-open order keeps a whole row's cache lines contiguous. The page-closed order spreads consecutive lines over banks and then ranks. The other two are expandable orders, which place the rank above everything else so that extra capacity adds ranks at the top of the address space. Software loads the configuration at start-up, and a write is accepted only while no request is in flight.

Requests arrive on a valid/ready stream and leave on a second valid/ready stream after one register stage. Back-pressure follows from that stage. A new request is taken when the stage is empty or is being emptied in the same cycle. A result held under back-pressure stays unchanged until it is taken.

Top module: `dram_addr_xlate`

## Requirements
- R1: In interleaved mode (mode register bit 2 = 0) the channel is address bit LINE_W (bit 6 by default). The channel-local address is the input with that bit removed and the upper bits shifted down by one.
- R2: In fill mode (mode bit 2 = 1) an address below the channel-0 capacity register (select 1) goes to channel 0 unchanged. Any other address goes to channel 1, with the capacity subtracted from it.
- R3: Scheme 0 (mode bits 1:0 = 0), from high bits to low: row, rank, bank, then the column-and-byte field of col_w + COL_OFS_W bits. The rank field is mode bits 4:3 wide, and rank 0's geometry applies. The column is the column-and-byte field shifted right by COL_OFS_W.
- R4: Scheme 1, from high bits to low: row, line-in-row, rank, bank, then the LINE_W byte-in-line bits. The column is {line, byte} shifted right by COL_OFS_W.
- R5: Scheme 2, applied to the offset inside the selected rank, from high bits to low: row, bank, column-and-byte. The selected rank's geometry applies.
- R6: Scheme 3, applied to the offset inside the selected rank, from high bits to low: row, line-in-row, bank, byte-in-line.
- R7: In schemes 2 and 3 the rank is the lowest index i whose limit register (select 2+i) is greater than the channel-local address. The rank offset is that address minus limit i-1, or minus zero for rank 0. Geometry registers sit at select 2+NUM_RANKS+i, with bank_w in bits 1:0, row_w in bits 8:4 and col_w in bits 15:12.
- R8: A channel-local address at or above the last limit register gives out_err = 1, and channel, rank, bank, row and column are all 0. This applies in every scheme.
- R9: A request is taken when in_valid and in_ready are both 1. Its result appears with out_valid one cycle later. in_ready is 0 while a result is waiting with out_ready = 0, and the held result does not change.
- R10: A configuration write that arrives while out_valid or in_valid is 1 is dropped. Later translations still use the old settings.
- R11: After reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | CFG_AW | Configuration register select |
| cfg_wdata | input | ADDR_W | Configuration write data |
| in_valid | input | 1 | Request address valid |
| in_ready | output | 1 | Request can be taken |
| in_addr | input | ADDR_W | Physical byte address |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result consumer ready |
| out_err | output | 1 | Address beyond the populated range |
| out_chan | output | 1 | Channel |
| out_rank | output | RANK_W | Rank |
| out_bank | output | 3 | Bank |
| out_row | output | 16 | Row |
| out_col | output | 12 | Column |

## Verification
The bench uses the default parameters: a 32-bit address, four ranks, 64-byte lines and an 8-byte column. These values are large enough for rank geometries of 2 bank bits, 12 or 13 row bits and 10 column bits. Four register settings are applied, one per scheme. The two baseline settings run in interleaved mode and the two expandable settings run in fill mode. Uneven rank sizes and an empty top rank bring limit matching, the channel-capacity split and the all-ones edge of each rank within reach. The directed tests cover a stall under back-pressure and a configuration write made while a request is held.

// File: rtl/dram_xlate_pkg.sv
package dram_xlate_pkg;

  localparam int MAX_BANK_W = 3;
  localparam int MAX_ROW_W  = 16;
  localparam int MAX_COL_W  = 12;

  typedef enum logic [1:0] {
    SCH_OPEN   = 2'd0,
    SCH_CLOSE  = 2'd1,
    SCH_XOPEN  = 2'd2,
    SCH_XCLOSE = 2'd3
  } scheme_e;

  typedef struct packed {
    logic [3:0] col_w;
    logic [4:0] row_w;
    logic [1:0] bank_w;
  } rank_geom_t;

endpackage

// File: rtl/dram_xlate_cfg.sv
module dram_xlate_cfg
  import dram_xlate_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int NUM_RANKS = 4,
  parameter int CFG_AW    = 4
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 wr_en,
  input  logic                                 busy,
  input  logic [CFG_AW-1:0]                    wr_sel,
  input  logic [ADDR_W-1:0]                    wr_data,
  output scheme_e                              scheme,
  output logic                                 asym,
  output logic [1:0]                           rank_bits,
  output logic [ADDR_W-1:0]                    ch0_cap,
  output logic [NUM_RANKS-1:0][ADDR_W-1:0]     limits,
  output rank_geom_t [NUM_RANKS-1:0]           geoms
);

  localparam int LIM_BASE  = 2;
  localparam int GEOM_BASE = 2 + NUM_RANKS;

  logic accept;
  assign accept = wr_en && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scheme    <= SCH_OPEN;
      asym      <= 1'b0;
      rank_bits <= 2'd0;
      ch0_cap   <= '0;
    end else if (accept) begin
      if (wr_sel == CFG_AW'(0)) begin
        scheme    <= scheme_e'(wr_data[1:0]);
        asym      <= wr_data[2];
        rank_bits <= wr_data[4:3];
      end
      if (wr_sel == CFG_AW'(1)) ch0_cap <= wr_data;
    end
  end

  for (genvar g = 0; g < NUM_RANKS; g++) begin : g_rank_regs
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        limits[g] <= '0;
        geoms[g]  <= '0;
      end else if (accept) begin
        if (wr_sel == CFG_AW'(LIM_BASE + g)) limits[g] <= wr_data;
        if (wr_sel == CFG_AW'(GEOM_BASE + g)) begin
          geoms[g].bank_w <= wr_data[1:0];
          geoms[g].row_w  <= wr_data[8:4];
          geoms[g].col_w  <= wr_data[15:12];
        end
      end
    end
  end

endmodule

// File: rtl/dram_xlate_chan.sv
module dram_xlate_chan #(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 6
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              asym,
  input  logic [ADDR_W-1:0] cap,
  output logic              chan,
  output logic [ADDR_W-1:0] local_addr
);

  logic [ADDR_W-2:0] squeezed;
  assign squeezed = {addr[ADDR_W-1:LINE_W+1], addr[LINE_W-1:0]};

  always_comb begin
    if (asym) begin
      chan       = (addr >= cap);
      local_addr = chan ? (addr - cap) : addr;
    end else begin
      chan       = addr[LINE_W];
      local_addr = {1'b0, squeezed};
    end
  end

endmodule

// File: rtl/dram_xlate_rank.sv
module dram_xlate_rank #(
  parameter int ADDR_W    = 32,
  parameter int NUM_RANKS = 4,
  parameter int RANK_W    = 2
) (
  input  logic [ADDR_W-1:0]                local_addr,
  input  logic [NUM_RANKS-1:0][ADDR_W-1:0] limits,
  output logic                             hit,
  output logic [RANK_W-1:0]                rank_idx,
  output logic [ADDR_W-1:0]                rank_offs
);

  logic [NUM_RANKS-1:0]             below;
  logic [NUM_RANKS-1:0][ADDR_W-1:0] base_of;

  for (genvar g = 0; g < NUM_RANKS; g++) begin : g_cmp
    assign below[g] = local_addr < limits[g];
    if (g == 0) begin : g_first
      assign base_of[g] = '0;
    end else begin : g_rest
      assign base_of[g] = limits[g-1];
    end
  end

  logic [ADDR_W-1:0] base;

  always_comb begin
    hit      = 1'b0;
    rank_idx = '0;
    base     = '0;
    for (int i = NUM_RANKS - 1; i >= 0; i--) begin
      if (below[i]) begin
        hit      = 1'b1;
        rank_idx = RANK_W'(i);
        base     = base_of[i];
      end
    end
    rank_offs = local_addr - base;
  end

endmodule

// File: rtl/dram_xlate_fields.sv
module dram_xlate_fields
  import dram_xlate_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LINE_W    = 6,
  parameter int COL_OFS_W = 3,
  parameter int RANK_W    = 2
) (
  input  logic [ADDR_W-1:0]     offs,
  input  scheme_e               scheme,
  input  logic [1:0]            rank_bits,
  input  rank_geom_t            geom,
  output logic [RANK_W-1:0]     rank_fld,
  output logic [MAX_BANK_W-1:0] bank,
  output logic [MAX_ROW_W-1:0]  row,
  output logic [MAX_COL_W-1:0]  col
);

  localparam int SW = 8;

  function automatic logic [ADDR_W-1:0] lowmask(input logic [SW-1:0] w);
    lowmask = (ADDR_W'(1) << w) - ADDR_W'(1);
  endfunction

  logic [SW-1:0]     z_w, v_w, s_w, b_w, r_w, l_w;
  logic [ADDR_W-1:0] colbyte, line_a, bank_a, rank_a, row_a;
  logic              line_first;

  always_comb begin
    z_w = SW'(LINE_W);
    v_w = SW'(COL_OFS_W);
    s_w = SW'(geom.col_w) + v_w;
    b_w = SW'(geom.bank_w);
    r_w = SW'(geom.row_w);
    l_w = scheme[1] ? '0 : SW'(rank_bits);
    line_first = (scheme == SCH_OPEN) || (scheme == SCH_XOPEN);
    line_a = '0;
    if (line_first) begin
      colbyte = offs & lowmask(s_w);
      bank_a  = (offs >> s_w) & lowmask(b_w);
      rank_a  = (offs >> (s_w + b_w)) & lowmask(l_w);
    end else begin
      bank_a  = (offs >> z_w) & lowmask(b_w);
      rank_a  = (offs >> (z_w + b_w)) & lowmask(l_w);
      line_a  = (offs >> (z_w + b_w + l_w)) & lowmask(s_w - z_w);
      colbyte = (line_a << z_w) | (offs & lowmask(z_w));
    end
    row_a = (offs >> (s_w + b_w + l_w)) & lowmask(r_w);
  end

  assign rank_fld = RANK_W'(rank_a);
  assign bank     = MAX_BANK_W'(bank_a);
  assign row      = MAX_ROW_W'(row_a);
  assign col      = MAX_COL_W'(colbyte >> v_w);

endmodule

// File: rtl/dram_addr_xlate.sv
module dram_addr_xlate
  import dram_xlate_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int NUM_RANKS = 4,
  parameter int LINE_W    = 6,
  parameter int COL_OFS_W = 3,
  localparam int RANK_W   = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
  localparam int CFG_AW   = $clog2(2 + 2 * NUM_RANKS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [CFG_AW-1:0]     cfg_sel,
  input  logic [ADDR_W-1:0]     cfg_wdata,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [ADDR_W-1:0]     in_addr,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic                  out_err,
  output logic                  out_chan,
  output logic [RANK_W-1:0]     out_rank,
  output logic [MAX_BANK_W-1:0] out_bank,
  output logic [MAX_ROW_W-1:0]  out_row,
  output logic [MAX_COL_W-1:0]  out_col
);

  scheme_e                          cfg_scheme;
  logic                             cfg_asym;
  logic [1:0]                       cfg_rank_bits;
  logic [ADDR_W-1:0]                cfg_cap;
  logic [NUM_RANKS-1:0][ADDR_W-1:0] cfg_limits;
  rank_geom_t [NUM_RANKS-1:0]       cfg_geoms;

  logic busy;
  assign busy = out_valid || in_valid;

  dram_xlate_cfg #(.ADDR_W(ADDR_W), .NUM_RANKS(NUM_RANKS), .CFG_AW(CFG_AW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .busy(busy), .wr_sel(cfg_sel),
    .wr_data(cfg_wdata), .scheme(cfg_scheme), .asym(cfg_asym),
    .rank_bits(cfg_rank_bits), .ch0_cap(cfg_cap), .limits(cfg_limits),
    .geoms(cfg_geoms)
  );

  logic              chan_c;
  logic [ADDR_W-1:0] local_c;

  dram_xlate_chan #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_chan (
    .addr(in_addr), .asym(cfg_asym), .cap(cfg_cap),
    .chan(chan_c), .local_addr(local_c)
  );

  logic              hit_c;
  logic [RANK_W-1:0] lim_rank_c;
  logic [ADDR_W-1:0] rank_offs_c;

  dram_xlate_rank #(.ADDR_W(ADDR_W), .NUM_RANKS(NUM_RANKS), .RANK_W(RANK_W)) u_rank (
    .local_addr(local_c), .limits(cfg_limits),
    .hit(hit_c), .rank_idx(lim_rank_c), .rank_offs(rank_offs_c)
  );

  logic              expandable;
  logic [ADDR_W-1:0] field_src;
  rank_geom_t        geom_sel;

  assign expandable = cfg_scheme[1];
  assign field_src  = expandable ? rank_offs_c : local_c;
  assign geom_sel   = expandable ? cfg_geoms[lim_rank_c] : cfg_geoms[0];

  logic [RANK_W-1:0]     bit_rank_c;
  logic [MAX_BANK_W-1:0] bank_c;
  logic [MAX_ROW_W-1:0]  row_c;
  logic [MAX_COL_W-1:0]  col_c;

  dram_xlate_fields #(
    .ADDR_W(ADDR_W), .LINE_W(LINE_W), .COL_OFS_W(COL_OFS_W), .RANK_W(RANK_W)
  ) u_fields (
    .offs(field_src), .scheme(cfg_scheme), .rank_bits(cfg_rank_bits),
    .geom(geom_sel), .rank_fld(bit_rank_c), .bank(bank_c), .row(row_c),
    .col(col_c)
  );

  logic take;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_err   <= 1'b0;
      out_chan  <= 1'b0;
      out_rank  <= '0;
      out_bank  <= '0;
      out_row   <= '0;
      out_col   <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_err   <= !hit_c;
      out_chan  <= hit_c ? chan_c : 1'b0;
      out_rank  <= hit_c ? (expandable ? lim_rank_c : bit_rank_c) : '0;
      out_bank  <= hit_c ? bank_c : '0;
      out_row   <= hit_c ? row_c : '0;
      out_col   <= hit_c ? col_c : '0;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/dram_addr_xlate_chk.sv
module dram_addr_xlate_chk
  import dram_xlate_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int NUM_RANKS = 4,
  parameter int LINE_W    = 6,
  parameter int RANK_W    = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cfg_we,
  input logic                  in_valid,
  input logic                  in_ready,
  input logic [ADDR_W-1:0]     in_addr,
  input logic                  out_valid,
  input logic                  out_ready,
  input logic                  out_err,
  input logic                  out_chan,
  input logic [RANK_W-1:0]     out_rank,
  input logic [MAX_BANK_W-1:0] out_bank,
  input logic [MAX_ROW_W-1:0]  out_row,
  input logic [MAX_COL_W-1:0]  out_col,
  input scheme_e               cfg_scheme,
  input logic                  cfg_asym,
  input logic [ADDR_W-1:0]     cfg_cap
);

  // R9: held result stays put under back-pressure
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_err) && $stable(out_chan)
      && $stable(out_rank) && $stable(out_bank) && $stable(out_row) && $stable(out_col));

  // R9: stalled stage refuses new requests
  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R9: accepted request shows up one cycle later
  p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R8: error results carry zero coordinates
  p_errzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_err |-> !out_chan && out_rank == '0 && out_bank == '0
      && out_row == '0 && out_col == '0);

  // R10: writes during traffic leave the settings untouched
  p_cfglock_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && (out_valid || in_valid) |=> $stable(cfg_scheme) && $stable(cfg_asym)
      && $stable(cfg_cap));

  // R1: interleaved channel follows the line-select bit
  p_sym_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !cfg_asym |=> out_err || out_chan == $past(in_addr[LINE_W]));

  // R2: fill mode keeps low addresses on channel 0
  p_asym_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && cfg_asym && in_addr < cfg_cap |=> out_err || !out_chan);

endmodule

bind dram_addr_xlate dram_addr_xlate_chk #(
  .ADDR_W(ADDR_W), .NUM_RANKS(NUM_RANKS), .LINE_W(LINE_W), .RANK_W(RANK_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .in_valid(in_valid),
  .in_ready(in_ready), .in_addr(in_addr), .out_valid(out_valid),
  .out_ready(out_ready), .out_err(out_err), .out_chan(out_chan),
  .out_rank(out_rank), .out_bank(out_bank), .out_row(out_row),
  .out_col(out_col), .cfg_scheme(cfg_scheme), .cfg_asym(cfg_asym),
  .cfg_cap(cfg_cap)
);

// File: tb/dram_addr_xlate_bench.sv
`timescale 1ns/1ps
module dram_addr_xlate_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_addr = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_err;
  logic        out_chan;
  logic [1:0]  out_rank;
  logic [2:0]  out_bank;
  logic [15:0] out_row;
  logic [11:0] out_col;

  always #4 clk = ~clk;

  dram_addr_xlate u_dram_addr_xlate (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .out_valid(out_valid), .out_ready(out_ready),
    .out_err(out_err), .out_chan(out_chan), .out_rank(out_rank),
    .out_bank(out_bank), .out_row(out_row), .out_col(out_col)
  );

  typedef struct packed {
    logic [1:0]  cfg;
    logic [31:0] addr;
    logic        err;
    logic        ch;
    logic [1:0]  rank;
    logic [2:0]  bank;
    logic [15:0] row;
    logic [11:0] col;
  } vec_t;

  // cfg 0: scheme 0 interleaved, 1: scheme 1 interleaved,
  // 2: scheme 2 fill mode, 3: scheme 3 fill mode
  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 32'h0000_0040, 1'b0, 1'b1, 2'd0, 3'd0, 16'h0000, 12'h000},
    '{2'd0, 32'h0000_0080, 1'b0, 1'b0, 2'd0, 3'd0, 16'h0000, 12'h008},
    '{2'd0, 32'h000B_A478, 1'b0, 1'b1, 2'd1, 3'd2, 16'h0005, 12'h247},
    '{2'd0, 32'h4000_0000, 1'b1, 1'b0, 2'd0, 3'd0, 16'h0000, 12'h000},
    '{2'd0, 32'h3FFF_FFFF, 1'b0, 1'b1, 2'd1, 3'd3, 16'h1FFF, 12'h3FF},
    '{2'd1, 32'h000F_0795, 1'b0, 1'b0, 2'd1, 3'd3, 16'h0007, 12'h20A},
    '{2'd1, 32'h0000_0080, 1'b0, 1'b0, 2'd0, 3'd1, 16'h0000, 12'h000},
    '{2'd2, 32'h1000_2010, 1'b0, 1'b0, 2'd1, 3'd1, 16'h0000, 12'h002},
    '{2'd2, 32'h2801_A008, 1'b0, 1'b1, 2'd1, 3'd1, 16'h0003, 12'h001},
    '{2'd2, 32'h17FF_FFFF, 1'b0, 1'b0, 2'd1, 3'd3, 16'h0FFF, 12'h3FF},
    '{2'd2, 32'h0FFF_FFFF, 1'b0, 1'b0, 2'd0, 3'd3, 16'h1FFF, 12'h3FF},
    '{2'd2, 32'h4000_0000, 1'b1, 1'b0, 2'd0, 3'd0, 16'h0000, 12'h000},
    '{2'd3, 32'h1000_01C5, 1'b0, 1'b0, 2'd1, 3'd3, 16'h0000, 12'h008},
    '{2'd3, 32'h2801_8040, 1'b0, 1'b1, 2'd1, 3'd1, 16'h0003, 12'h000},
    '{2'd3, 32'h1800_0000, 1'b0, 1'b1, 2'd0, 3'd0, 16'h0000, 12'h000},
    '{2'd3, 32'h2000_0000, 1'b0, 1'b1, 2'd0, 3'd0, 16'h1000, 12'h000}
  };

  int applied = 0;
  int bad = 0;
  bit finished = 0;

  function automatic string tag_of(input int i);
    case (i)
      0:  tag_of = "R1";
      1, 2, 4: tag_of = "R3";
      3, 11: tag_of = "R8";
      5, 6: tag_of = "R4";
      7:  tag_of = "R5";
      8, 14, 15: tag_of = "R2";
      9, 10: tag_of = "R7";
      default: tag_of = "R6";
    endcase
  endfunction

  task automatic check(input string req, input logic [36:0] got, input logic [36:0] exp);
    applied++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [36:0] outs();
    outs = {out_valid, out_err, out_chan, out_rank, out_bank, out_row, out_col};
  endfunction

  task automatic wr(input logic [3:0] sel, input logic [31:0] data);
    @(negedge clk);
    while (out_valid) @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic load_cfg(input logic [1:0] k);
    logic [31:0] modes [4];
    modes = '{32'h08, 32'h09, 32'h06, 32'h07};
    wr(4'd0, modes[k]);
    if (k < 2) begin
      wr(4'd2, 32'h1000_0000); wr(4'd3, 32'h2000_0000);
      wr(4'd4, 32'h2000_0000); wr(4'd5, 32'h2000_0000);
      for (int r = 0; r < 4; r++) wr(4'(6 + r), 32'h0000_A0D2);
    end else begin
      wr(4'd1, 32'h1800_0000);
      wr(4'd2, 32'h1000_0000); wr(4'd3, 32'h1800_0000);
      wr(4'd4, 32'h2800_0000); wr(4'd5, 32'h2800_0000);
      wr(4'd6, 32'h0000_A0D2); wr(4'd7, 32'h0000_A0C2);
      wr(4'd8, 32'h0000_A0D2); wr(4'd9, 32'h0000_A0D2);
    end
  endtask

  task automatic send(input logic [31:0] a);
    @(negedge clk);
    in_valid = 1'b1; in_addr = a;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [36:0] expect_of(input vec_t v);
    expect_of = {1'b1, v.err, v.ch, v.rank, v.bank, v.row, v.col};
  endfunction

  initial begin
    repeat (30000) @(posedge clk);
    if (!finished) begin
      bad++;
      applied++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end

  initial begin
    logic [1:0] cur;
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11", {35'd0, out_valid, in_ready}, {35'd0, 1'b0, 1'b1});
    rst_n = 1'b1;
    @(negedge clk);
    check("R11", {35'd0, out_valid, in_ready}, {35'd0, 1'b0, 1'b1});

    cur = 2'd0;
    load_cfg(cur);
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].cfg != cur) begin
        cur = VECS[i].cfg;
        load_cfg(cur);
      end
      send(VECS[i].addr);
      check(tag_of(i), outs(), expect_of(VECS[i]));
    end

    // R9: back-pressure holds result and blocks input
    @(negedge clk);
    out_ready = 1'b0;
    send(32'h1800_0000);
    in_valid = 1'b1; in_addr = 32'h2801_8040;
    check("R9", {outs()[36:1], in_ready}, {expect_of(VECS[14])[36:1], 1'b0});
    @(negedge clk);
    check("R9", outs(), expect_of(VECS[14]));
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9", outs(), expect_of(VECS[13]));
    @(negedge clk);
    check("R9", {35'd0, out_valid, in_ready}, {35'd0, 1'b0, 1'b1});

    // R10: write while a result is held is dropped
    out_ready = 1'b0;
    send(32'h1000_01C5);
    cfg_we = 1'b1; cfg_sel = 4'd0; cfg_wdata = 32'h08;
    @(negedge clk);
    cfg_we = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    send(32'h1000_01C5);
    check("R10", outs(), expect_of(VECS[12]));
    send(32'h2801_8040);
    check("R10", outs(), expect_of(VECS[13]));

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

endmodule